// File: doc/BRIEF.md
# Cascadable Shift-and-Latch Sink Output Expander

This block turns a three-wire serial stream into eight parallel on/off controls for low-side sink drivers. A serial bit stream is clocked into a shift stage by an external shift clock. A separate latch clock then copies the whole stage into a storage latch, and that latch drives the outputs. Because the stage and the latch are kept apart, new data can be shifted in while the loads still show the previous pattern. The serial output carries the last shift stage, so several expanders wired output-to-input behave as one long register. All of them update together on one shared latch edge.

Every pin arrives asynchronously. Each one passes through a synchronizer in the system clock domain. The shift and latch clocks are then turned into one-cycle strobes by rising-edge detection. An active-low clear empties only the shift stage. An active-low output enable blanks every output without touching the stored pattern. Each output is a registered active-high "sink on" bit: 1 means the channel conducts and 0 means it is off.

Top module: `sipo_latch_expander`

## Requirements
- R1: During and after synchronous reset, with no edges applied, the shift stage and the storage latch are zero, `sink_on` is all zeros and `ser_out` is 0.
- R2: Each rising edge of `shift_clk` moves the shift stage one place toward the higher index and loads `ser_in` into index 0. A byte sent most significant bit first therefore lands with data bit k at output index k after WIDTH edges.
- R3: A rising edge of `latch_clk` copies the whole shift stage into the storage latch at once. With `out_en_n` low, `sink_on` shows the new pattern no later than 4 system clocks after the edge. Without a latch edge, `sink_on` holds its value while shifting goes on.
- R4: `ser_out` always equals the highest shift stage. When N devices are chained, N×WIDTH shift edges and one shared latch edge load the last-shifted WIDTH bits into the first device, and earlier bits into later devices.
- R5: While `shift_clr_n` is low, the shift stage is held at zero and `ser_out` is 0. The storage latch and `sink_on` keep their values until the next latch edge.
- R6: While `out_en_n` is high, `sink_on` is all zeros. When it returns low, `sink_on` shows the latch contents again, with no reload needed.
- R7: When a shift edge and a latch edge fall in the same system cycle, the latch takes the shift stage value from before that shift.
- R8: A shift clock that stays high for many system cycles causes exactly one shift.
- R9: `ser_in` must stay stable for at least two system clocks before and after each rising edge of `shift_clk`. Each clock pulse must be seen high for at least two samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data input, asynchronous |
| shift_clk | input | 1 | Shift clock, asynchronous; acts on its rising edge |
| latch_clk | input | 1 | Latch clock, asynchronous; acts on its rising edge |
| shift_clr_n | input | 1 | Active-low clear of the shift stage |
| out_en_n | input | 1 | Active-low output enable |
| sink_on | output | WIDTH | Registered per-channel sink control, 1 = on |
| ser_out | output | 1 | Cascade output, highest shift stage |

## Verification
The embedded properties check the following on every cycle:
- each strobe lasts exactly one cycle;
- a strobed shift, a clear and a latch load each produce the correct next state;
- the latch keeps its value between strobes;
- a high enable blanks the outputs;
- the synchronized serial data and clock pulses meet the two-sample stability window.

Some behaviours only the bench scenarios can show. These are the end-to-end bit ordering across a two-device chain, the rule that the latch wins over the shift in a same-cycle tie, the single shift from a long pulse, and the return of stored data after blanking or after a clear with no reload.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Asynchronous control pins, gathered for one shared synchronizer
  typedef struct packed {
    logic din;
    logic sclk;
    logic lclk;
    logic clr_n;
    logic oe_n;
  } pin_bundle_t;

  localparam int unsigned PIN_COUNT = $bits(pin_bundle_t);
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rise_strobe.sv
module rise_strobe (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic stb
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign stb = lvl & ~prev_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb);                                   // R8
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    stb |=> lvl);                                    // R9
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             stb,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (!clr_n) q <= '0;
    else if (stb)    q <= {q[WIDTH-2:0], din};
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> q == '0);                             // R5
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (stb && clr_n) |=> q == {$past(q[WIDTH-2:0]), $past(din)}); // R2
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!stb && clr_n) |=> $stable(q));                 // R8
endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (stb) q <= d;
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    stb |=> q == $past(d));                          // R7
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(q));                            // R5
endmodule

// File: rtl/sipo_latch_expander.sv
module sipo_latch_expander
  import sipo_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             latch_clk,
  input  logic             shift_clr_n,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] sink_on,
  output logic             ser_out
);
  localparam pin_bundle_t PIN_RST = '{din: 1'b0, sclk: 1'b0, lclk: 1'b0,
                                      clr_n: 1'b1, oe_n: 1'b1};

  pin_bundle_t pins_raw, pins_s;
  logic shift_stb, latch_stb;
  logic [WIDTH-1:0] shift_q, latch_q, sink_q;

  assign pins_raw = '{din: ser_in, sclk: shift_clk, lclk: latch_clk,
                      clr_n: shift_clr_n, oe_n: out_en_n};

  bit_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  rise_strobe u_shift_edge (.clk(clk), .rst(rst), .lvl(pins_s.sclk), .stb(shift_stb));
  rise_strobe u_latch_edge (.clk(clk), .rst(rst), .lvl(pins_s.lclk), .stb(latch_stb));

  shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst(rst), .clr_n(pins_s.clr_n), .stb(shift_stb),
    .din(pins_s.din), .q(shift_q)
  );

  hold_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .stb(latch_stb), .d(shift_q), .q(latch_q)
  );

  always_ff @(posedge clk) begin
    if (rst)              sink_q <= '0;
    else if (pins_s.oe_n) sink_q <= '0;
    else                  sink_q <= latch_q;
  end

  assign sink_on = sink_q;
  assign ser_out = shift_q[WIDTH-1];

  AST_BLANK_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    pins_s.oe_n |=> sink_on == '0);                  // R6
  AST_FOLLOW_LATCH: assert property (@(posedge clk) disable iff (rst)
    !pins_s.oe_n |=> sink_on == $past(latch_q));     // R3
  AST_CASCADE_OUT: assert property (@(posedge clk) disable iff (rst)
    (shift_stb && pins_s.clr_n) |=> ser_out == $past(shift_q[WIDTH-2])); // R4
  AST_DIN_SETUP: assert property (@(posedge clk) disable iff (rst)
    shift_stb |-> pins_s.din == $past(pins_s.din));  // R9
  AST_DIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    shift_stb |=> $stable(pins_s.din));              // R9
endmodule

// File: tb/sipo_latch_expander_bench.sv
module sipo_latch_expander_bench;
  localparam int unsigned W      = 8;
  localparam int unsigned N_DEV  = 2;
  localparam int unsigned TOT    = W * N_DEV;
  localparam time         CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0, shift_clk = 1'b0, latch_clk = 1'b0;
  logic shift_clr_n = 1'b1, out_en_n = 1'b1;
  logic [N_DEV:0]   link;
  logic [TOT-1:0]   sink_all;
  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign link[0] = ser_in;

  for (genvar i = 0; i < N_DEV; i++) begin : gen_chain
    sipo_latch_expander #(.WIDTH(W)) u_sipo_latch_expander (
      .clk(clk), .rst(rst), .ser_in(link[i]), .shift_clk(shift_clk),
      .latch_clk(latch_clk), .shift_clr_n(shift_clr_n), .out_en_n(out_en_n),
      .sink_on(sink_all[i*W +: W]), .ser_out(link[i+1])
    );
  end

  // {word shifted MSB first, out_en_n, expected concatenated sink_on}
  localparam logic [32:0] VEC [6] = '{
    {16'hA5C3, 1'b0, 16'hA5C3},
    {16'h0001, 1'b0, 16'h0001},
    {16'h8000, 1'b0, 16'h8000},
    {16'hFFFF, 1'b1, 16'h0000},
    {16'h1234, 1'b0, 16'h1234},
    {16'h0F0F, 1'b0, 16'h0F0F}
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [TOT-1:0] act, input logic [TOT-1:0] exp,
                       input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, input int high_cyc);
    ser_in = b;
    wait_cyc(3);
    shift_clk = 1'b1;
    wait_cyc(high_cyc);
    shift_clk = 1'b0;
    wait_cyc(3);
  endtask

  task automatic load_word(input logic [TOT-1:0] w);
    for (int i = TOT - 1; i >= 0; i--) shift_bit(w[i], 3);
  endtask

  task automatic latch_now();
    latch_clk = 1'b1;
    wait_cyc(3);
    latch_clk = 1'b0;
    wait_cyc(5);
  endtask

  task automatic clear_stage();
    shift_clr_n = 1'b0;
    wait_cyc(4);
    shift_clr_n = 1'b1;
    wait_cyc(4);
  endtask

  initial begin
    wait_cyc(2);
    check(sink_all, '0, "R1 in reset");
    wait_cyc(3);
    rst = 1'b0;
    out_en_n = 1'b0;
    wait_cyc(6);
    check(sink_all, '0, "R1 after reset");
    check({15'd0, link[N_DEV]}, '0, "R1 ser_out");

    // Table walk: R2/R3/R4/R6 through the two-device chain
    for (int v = 0; v < 6; v++) begin
      out_en_n = VEC[v][16];
      load_word(VEC[v][32:17]);
      latch_now();
      check(sink_all, VEC[v][15:0], "R2 R3 R4 vector");
    end

    // R6: blank, then restore without reloading
    out_en_n = 1'b0;
    wait_cyc(5);
    check(sink_all, 16'h0F0F, "R6 restore");
    out_en_n = 1'b1;
    wait_cyc(5);
    check(sink_all, 16'h0000, "R6 blank");
    out_en_n = 1'b0;
    wait_cyc(5);
    check(sink_all, 16'h0F0F, "R6 re-enable");

    // R4: cascade output shows highest stage of last device
    load_word(16'h8001);
    check({15'd0, link[N_DEV]}, 16'h0001, "R4 ser_out high");
    // R3: outputs hold while shifting without a latch edge
    check(sink_all, 16'h0F0F, "R3 hold during shift");

    // R5: clear empties shift stage only
    clear_stage();
    check({15'd0, link[N_DEV]}, 16'h0000, "R5 ser_out cleared");
    check(sink_all, 16'h0F0F, "R5 latch kept");
    latch_now();
    check(sink_all, 16'h0000, "R5 cleared stage latched");

    // R8: a long shift pulse shifts once
    shift_bit(1'b1, 20);
    latch_now();
    check(sink_all, 16'h0001, "R8 long pulse");

    // R7: shift and latch in the same cycle, latch takes pre-shift value
    ser_in = 1'b1;
    wait_cyc(3);
    shift_clk = 1'b1;
    latch_clk = 1'b1;
    wait_cyc(3);
    shift_clk = 1'b0;
    latch_clk = 1'b0;
    wait_cyc(6);
    check(sink_all, 16'h0001, "R7 same-cycle tie");
    latch_now();
    check(sink_all, 16'h0003, "R7 next latch");

    // R1: reset mid-run returns everything to zero
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(6);
    check(sink_all, '0, "R1 reapplied");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule